// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a two-wire serial slave that exposes ten byte-wide registers, at register addresses 00h to 09h, to a bus master. A master opens an access with a START condition and a device identification byte that carries the 7-bit slave address and a read/write bit. In a write, the first byte after the address loads an internal register pointer, and any further bytes are stored at that pointer. In a read, bytes are returned from the pointer. After every byte moved in either direction the pointer steps to the next register, so a burst walks through the bank without being readdressed until the master ends it with STOP.

The first seven registers (00h to 06h) hold clock and calendar values. A power-fail input fences them off while the supply is low: writes to them are dropped and reads return all ones. The other three registers stay reachable. Register 09h is a flag register that stores only its top bit. Both bus lines are oversampled on the system clock through two-flop synchronisers. SDA is driven open-drain through an output-enable that pulls the line low.

Top module: `twi_regbank_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP at any point, even in the middle of a byte, returns the slave to idle with SDA released and leaves the register pointer unchanged.
- R2: The address byte is sent MSB first: seven address bits, then R/W (1 = read). On a match with DEV_ADDR the slave pulls SDA low for the ninth clock. On a mismatch it never drives SDA until the next START.
- R3: In a write, the first byte after the address loads the pointer and is acknowledged. A value of 0Ah or above loads 00h.
- R4: Each later write byte is stored at the pointer and acknowledged, and the pointer then advances. From 09h it wraps to 00h.
- R5: In a read, each byte is driven MSB first from the pointer, and the pointer advances after every byte, wrapping from 09h to 00h. Reading continues while the master acknowledges. After a NACK the slave releases SDA and stays silent on further clocks.
- R6: A repeated START, or a STOP followed by a new START, keeps the pointer. A pointer write followed by a read returns the addressed register.
- R7: While pwr_fail_i is 1, writes to 00h to 06h are discarded and reads of them return FFh. Those bytes are still acknowledged and still advance the pointer. Registers 07h to 09h behave normally.
- R8: In register 09h only bit 7 is stored, and bits 6:0 always read 0. After reset every register reads 00h except 09h, which reads 80h.
- R9: SDA is released (sda_oe_o = 0) after reset. The slave starts driving SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pwr_fail_i | input | 1 | 1 while the supply is below threshold; locks registers 00h to 06h |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases the line |

## Verification
Power-fail lockout and pointer advance can fall in the same cycle. A data byte that lands on a locked register still completes the ACK and steps the pointer in the cycle where the lockout drops the store. The bench provokes this by raising power-fail before a write burst that runs from 05h across the locked boundary into 07h. It then reads the burst back. The locked registers must return FFh while the fence is up and their old contents once it drops, and 07h must hold the third byte. A pointer that stalled, or a store that leaked through, shows up as a wrong byte at a known position in the read-back.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_SACK,
        ST_RDATA,
        ST_MACK
    } twi_state_e;

    // Byte-level engine context
    typedef struct packed {
        twi_state_e state;
        twi_state_e after;   // state entered once the slave ACK ends
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [7:0] ptr;
        logic       sda_oe;
        logic       nack;
    } twi_ctx_t;

    // Synchroniser and edge history for both lines
    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } twi_sync_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    twi_sync_t sync_d, sync_q;

    always_comb begin
        sync_d.scl_m = scl_i;
        sync_d.scl_s = sync_q.scl_m;
        sync_d.scl_p = sync_q.scl_s;
        sync_d.sda_m = sda_i;
        sync_d.sda_s = sync_q.sda_m;
        sync_d.sda_p = sync_q.sda_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;   // idle bus is high
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_s;
    assign sda_s     = sync_q.sda_s;
    assign scl_rise  =  sync_q.scl_s & ~sync_q.scl_p;
    assign scl_fall  = ~sync_q.scl_s &  sync_q.scl_p;
    assign start_det =  sync_q.scl_s & sync_q.scl_p &  sync_q.sda_p & ~sync_q.sda_s;
    assign stop_det  =  sync_q.scl_s & sync_q.scl_p & ~sync_q.sda_p &  sync_q.sda_s;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
    parameter int NUM_REGS   = 10,
    parameter int CLOCK_REGS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);

    localparam int FLAG_IDX = NUM_REGS - 1;
    localparam int IDX_W    = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][7:0] bank;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_VAL  = (g == FLAG_IDX) ? 8'h80 : 8'h00;
        localparam bit         LOCKABLE = (g < CLOCK_REGS);
        logic [7:0] reg_d, reg_q;

        always_comb begin
            reg_d = reg_q;
            if (wr_en && wr_addr == 8'(g) && !(LOCKABLE && pwr_fail)) begin
                reg_d = (g == FLAG_IDX) ? {wr_data[7], 7'b0} : wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) reg_q <= RST_VAL;
            else        reg_q <= reg_d;
        end

        assign bank[g] = reg_q;
    end

    always_comb begin
        if (rd_addr >= 8'(NUM_REGS))
            rd_data = 8'h00;
        else if (pwr_fail && rd_addr < 8'(CLOCK_REGS))
            rd_data = 8'hFF;
        else
            rd_data = bank[rd_addr[IDX_W-1:0]];
    end

endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h68,
    parameter int         NUM_REGS   = 10,
    parameter int         CLOCK_REGS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic pwr_fail_i,
    output logic sda_oe_o
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data, cur_ptr;

    twi_ctx_t ctx_d, ctx_q;

    twi_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .CLOCK_REGS (CLOCK_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail_i),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    function automatic logic [7:0] ptr_step(input logic [7:0] p);
        return (p == 8'(NUM_REGS - 1)) ? 8'd0 : p + 8'd1;
    endfunction

    always_comb begin
        ctx_d   = ctx_q;
        wr_en   = 1'b0;
        wr_addr = ctx_q.ptr;
        wr_data = ctx_q.shreg;
        rd_addr = ctx_q.ptr;

        if (stop_det) begin
            ctx_d.state  = ST_IDLE;
            ctx_d.sda_oe = 1'b0;
        end else if (start_det) begin
            ctx_d.state  = ST_ADDR;
            ctx_d.bitcnt = '0;
            ctx_d.sda_oe = 1'b0;
        end else begin
            unique case (ctx_q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        ctx_d.shreg  = {ctx_q.shreg[6:0], sda_s};
                        ctx_d.bitcnt = ctx_q.bitcnt + 4'd1;
                    end else if (scl_fall && ctx_q.bitcnt == 4'd8) begin
                        ctx_d.bitcnt = '0;
                        ctx_d.state  = ST_SACK;
                        ctx_d.sda_oe = 1'b1;
                        ctx_d.after  = ST_WDATA;
                        if (ctx_q.state == ST_ADDR) begin
                            if (ctx_q.shreg[7:1] == DEV_ADDR) begin
                                ctx_d.after = ctx_q.shreg[0] ? ST_RDATA : ST_PTR;
                            end else begin
                                ctx_d.state  = ST_IDLE;
                                ctx_d.sda_oe = 1'b0;
                            end
                        end else if (ctx_q.state == ST_PTR) begin
                            ctx_d.ptr = (ctx_q.shreg < 8'(NUM_REGS)) ? ctx_q.shreg : 8'd0;
                        end else begin
                            wr_en     = 1'b1;
                            ctx_d.ptr = ptr_step(ctx_q.ptr);
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        ctx_d.state  = ctx_q.after;
                        ctx_d.bitcnt = '0;
                        ctx_d.sda_oe = 1'b0;
                        if (ctx_q.after == ST_RDATA) begin
                            ctx_d.shreg  = rd_data;
                            ctx_d.sda_oe = ~rd_data[7];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (ctx_q.bitcnt == 4'd7) begin
                            ctx_d.sda_oe = 1'b0;
                            ctx_d.state  = ST_MACK;
                            ctx_d.ptr    = ptr_step(ctx_q.ptr);
                        end else begin
                            ctx_d.shreg  = {ctx_q.shreg[6:0], 1'b0};
                            ctx_d.sda_oe = ~ctx_q.shreg[6];
                            ctx_d.bitcnt = ctx_q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        ctx_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (ctx_q.nack) begin
                            ctx_d.state = ST_IDLE;
                        end else begin
                            ctx_d.state  = ST_RDATA;
                            ctx_d.bitcnt = '0;
                            ctx_d.shreg  = rd_data;
                            ctx_d.sda_oe = ~rd_data[7];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q       <= '0;
            ctx_q.state <= ST_IDLE;
            ctx_q.after <= ST_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign sda_oe_o = ctx_q.sda_oe;
    assign cur_ptr  = ctx_q.ptr;

endmodule

// File: rtl/twi_regbank_chk.sv
module twi_regbank_chk #(
    parameter int NUM_REGS   = 10,
    parameter int CLOCK_REGS = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       pwr_fail,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] ptr,
    input logic [7:0] rd_addr,
    input logic [7:0] rd_data
);

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < 8'(NUM_REGS));

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'(NUM_REGS - 1)) |=> ptr == 8'd0);

    assert_locked_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && rd_addr < 8'(CLOCK_REGS)) |-> rd_data == 8'hFF);

    assert_flag_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'(NUM_REGS - 1)) |-> rd_data[6:0] == 7'd0);

    assert_drive_on_low_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

endmodule

bind twi_regbank_slave twi_regbank_chk #(
    .NUM_REGS   (NUM_REGS),
    .CLOCK_REGS (CLOCK_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_oe   (sda_oe_o),
    .pwr_fail (pwr_fail_i),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ptr      (cur_ptr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/sim_twi_regbank_slave.sv
module sim_twi_regbank_slave;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;      // system clocks per quarter bit
    localparam logic [6:0] DEV        = 7'h68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pf = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twi_regbank_slave #(.DEV_ADDR(DEV)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .pwr_fail_i (pf),
        .sda_oe_o   (sda_oe)
    );

    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 0;
    logic [7:0] mdl [10];
    int         ptr_m = 0;

    task automatic report;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        return (pf && a < 7) ? 8'hFF : mdl[a];
    endfunction

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qw;
        m_scl = 1'b1; qw;
        m_sda = 1'b0; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qw;
        m_scl = 1'b1; qw;
        m_sda = 1'b1; qw;
    endtask

    task automatic put_bit(input logic v);
        m_sda = v;    qw;
        m_scl = 1'b1; qw; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic get_bit(output logic v);
        m_sda = 1'b1; qw;
        m_scl = 1'b1; qw;
        v = sda_bus;  qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(~m_ack);
    endtask

    // START, address for write, pointer byte; no STOP
    task automatic set_ptr(input logic [7:0] p);
        logic ack;
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        chk("R2", "address ACK (write)", {7'd0, ack}, 8'd1);
        send_byte(p, ack);
        chk("R3", "pointer ACK", {7'd0, ack}, 8'd1);
        ptr_m = (p < 8'd10) ? int'(p) : 0;
    endtask

    task automatic write_seq(input logic [7:0] p, input int n,
                             input logic [7:0] base, input logic [7:0] step);
        logic       ack;
        logic [7:0] d;
        set_ptr(p);
        for (int i = 0; i < n; i++) begin
            d = base + 8'(i) * step;
            send_byte(d, ack);
            chk("R4", "data ACK", {7'd0, ack}, 8'd1);
            if (!(pf && ptr_m < 7)) mdl[ptr_m] = (ptr_m == 9) ? {d[7], 7'd0} : d;
            ptr_m = (ptr_m == 9) ? 0 : ptr_m + 1;
        end
        bus_stop;
    endtask

    // (repeated) START, address for read, n bytes, NACK on last, STOP
    task automatic read_seq(input int n, input string req);
        logic       ack;
        logic [7:0] b;
        bus_start;
        send_byte({DEV, 1'b1}, ack);
        chk("R2", "address ACK (read)", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            chk(req, $sformatf("read reg %0d", ptr_m), b, exp_rd(ptr_m));
            ptr_m = (ptr_m == 9) ? 0 : ptr_m + 1;
        end
        bus_stop;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 10; i++) mdl[i] = (i == 9) ? 8'h80 : 8'h00;
        chk("R9", "sda released after reset", {7'd0, sda_oe}, 8'd0);
        set_ptr(8'h00);
        read_seq(10, "R8");
    endtask

    task automatic t_burst_wrap;
        write_seq(8'h03, 10, 8'hC3, 8'h11);   // 03h..09h then 00h..02h
        set_ptr(8'h00);
        read_seq(10, "R4");
    endtask

    task automatic t_flag;
        write_seq(8'h09, 1, 8'hFF, 8'h00);
        set_ptr(8'h09);
        read_seq(2, "R8");                    // 09h reads 80h, then wraps to 00h
    endtask

    task automatic t_ptr_oob;
        set_ptr(8'h0C);
        read_seq(1, "R3");
    endtask

    task automatic t_read_wrap;
        logic x;
        set_ptr(8'h08);
        read_seq(4, "R5");                    // 08h, 09h, 00h, 01h
        // slave must keep quiet on clocks after a STOP-free NACK too
        bus_start;
        begin
            logic       ack;
            logic [7:0] b;
            send_byte({DEV, 1'b1}, ack);
            chk("R6", "address ACK after restart", {7'd0, ack}, 8'd1);
            recv_byte(b, 1'b0);
            chk("R6", "pointer kept across STOP/START", b, exp_rd(ptr_m));
            ptr_m = (ptr_m == 9) ? 0 : ptr_m + 1;
        end
        for (int i = 0; i < 3; i++) begin
            get_bit(x);
            chk("R5", "line released after NACK", {7'd0, x}, 8'd1);
        end
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic ack;
        bus_start;
        send_byte({DEV ^ 7'h01, 1'b0}, ack);
        chk("R2", "no ACK for foreign address", {7'd0, ack}, 8'd0);
        send_byte(8'h00, ack);
        chk("R2", "silent until next START", {7'd0, ack}, 8'd0);
        bus_stop;
        read_seq(1, "R2");                    // pointer untouched
    endtask

    task automatic t_stop_abort;
        logic ack;
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        chk("R2", "address ACK", {7'd0, ack}, 8'd1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop;
        chk("R1", "sda released after STOP", {7'd0, sda_oe}, 8'd0);
        read_seq(1, "R1");                    // partial pointer byte discarded
    endtask

    task automatic t_pwr_fail;
        pf = 1'b1;
        write_seq(8'h05, 3, 8'h55, 8'h11);    // 05h,06h dropped, 07h stored
        set_ptr(8'h04);
        read_seq(4, "R7");
        pf = 1'b0;
        set_ptr(8'h05);
        read_seq(3, "R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (R1..): actual timeout expected completion");
        report;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_burst_wrap;
        t_flag;
        t_ptr_oob;
        t_read_wrap;
        t_mismatch;
        t_stop_abort;
        t_pwr_fail;
        repeat (20) @(negedge clk);
        report;
    end

endmodule